// File: doc/BRIEF.md
# Gate Schedule Start Timer

This block decides when a freshly loaded gate schedule takes over a switch port. Software picks a port through a select register, loads a start instant (a nanosecond value written as two 16-bit halves plus a 3-bit seconds value), and then issues one command write that arms the timer and says whether the schedule should be switched in. The block compares the armed instant against the synchronised time-of-day inputs every clock. Only the seconds modulo 8 take part in the comparison, so a start can be at most eight seconds ahead.

Until the start instant is reached, an enabled port presents its administrative gate mask, which is normally all gates open. When the instant matches, the block emits a single-cycle start pulse and clears the arm bit. If the switch bit was set, the port enters the running state and tells the gate engine to begin its cycle. After that, the block pulses again each time one programmed cycle time has elapsed, measured from the start instant. A zero command write withdraws a pending start. Clearing the gate enable puts the port back to ordinary forwarding.

Top module: `sched_start_arm`

## Requirements
- R1: After reset, every port is unarmed, not running and not holding. Its gate mask reads 0xFF and no pulse is issued.
- R2: Writing address 0 loads the port-select value from wr_data[1:0]. Writes to addresses 1 to 6 affect only the selected port.
- R3: Address 1 is the gate control. Bit 0 is the gate enable and bits 15:8 are the administrative mask. An enabled port that is not running holds: hold_o=1 and its mask shows the administrative value. A disabled port shows 0xFF and hold_o=0. Writing enable=0 also clears the port's arm and running state.
- R4: Address 2 takes start nanoseconds [15:0] and address 3 takes [29:16] from wr_data[13:0]. Address 4 is the command: bit 0 arms, bit 1 selects switch-in, and bits 4:2 hold the seconds. armed_o follows bit 0 from the next cycle.
- R5: An armed port fires when tod_sec equals the armed seconds and tod_ns equals the armed nanoseconds on a clock edge. start_pulse_o is high for exactly the following cycle and armed_o drops in that same cycle. A difference in seconds or in either nanosecond half prevents firing.
- R6: A command write of zero cancels a pending start. The start does not fire later, and it also does not fire when the cancelling write coincides with a matching time.
- R7: A firing with the switch bit set makes running_o go high and hold_o go low, and raises cycle_pulse_o together with start_pulse_o. A firing without the switch bit leaves running_o unchanged.
- R8: Address 5 takes cycle time [15:0] and address 6 takes [31:16]. While running, cycle_pulse_o is raised each time the nanoseconds elapsed since the last cycle start reach the cycle time. Elapsed time counts correctly across the nanosecond rollover at 1,000,000,000, and any excess carries into the next cycle. A cycle time of zero produces no restart pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tod_sec | input | 3 | Time-of-day seconds, low three bits |
| tod_ns | input | 30 | Time-of-day nanoseconds, 0 to 999,999,999 |
| armed_o | output | 4 | Per-port pending start |
| running_o | output | 4 | Per-port schedule running |
| hold_o | output | 4 | Per-port holding on the administrative mask |
| start_pulse_o | output | 4 | Per-port one-cycle start strobe |
| cycle_pulse_o | output | 4 | Per-port cycle (re)start strobe |
| gate_mask_o | output | 32 | Per-port mask, port p in bits [8p+7:8p] |

## Verification
The compare path is exercised with a table of armed instants against presented times. The table covers an exact hit, a hit whose full seconds differ by a multiple of eight, and misses that differ only in the seconds, only in the low nanosecond half, or only in the high half. Together these separate a correct modulo-8 compare from one that ignores the seconds or drops either half of the nanosecond value. Free-running time then checks three more things: the start latency, the number of restart pulses for a short cycle, and the exact tick count to the first restart for a cycle that uses the upper half and crosses the nanosecond rollover. Directed cases cover a cancel before the instant, a cancel in the same cycle as a match, port isolation, and disabling the gate.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [2:0] {
    REG_PSEL   = 3'd0,
    REG_CTRL   = 3'd1,
    REG_NS_LO  = 3'd2,
    REG_NS_HI  = 3'd3,
    REG_CMD    = 3'd4,
    REG_CYC_LO = 3'd5,
    REG_CYC_HI = 3'd6
  } sas_reg_e;

  localparam logic [31:0] NS_PER_SEC = 32'd1_000_000_000;
endpackage

// File: rtl/sas_ns_delta.sv
module sas_ns_delta #(
  parameter int NS_W  = 30,
  parameter int OUT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NS_W-1:0]  tod_ns,
  output logic [OUT_W-1:0] ns_delta
);
  import sas_pkg::*;

  logic [NS_W-1:0] prev_q;

  always_comb begin
    if (tod_ns >= prev_q)
      ns_delta = OUT_W'(tod_ns) - OUT_W'(prev_q);
    else
      ns_delta = OUT_W'(tod_ns) + OUT_W'(NS_PER_SEC) - OUT_W'(prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= tod_ns;
  end
endmodule

// File: rtl/sas_port.sv
module sas_port #(
  parameter int NS_W   = 30,
  parameter int SEC_W  = 3,
  parameter int GATE_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [SEC_W-1:0]      tod_sec,
  input  logic [NS_W-1:0]       tod_ns,
  input  logic [2*DATA_W-1:0]   ns_delta,
  output logic                  armed_o,
  output logic                  running_o,
  output logic                  hold_o,
  output logic                  start_pulse_o,
  output logic                  cycle_pulse_o,
  output logic [GATE_W-1:0]     gate_mask_o
);
  import sas_pkg::*;

  localparam int CYC_W   = 2 * DATA_W;
  localparam int NS_HI_W = NS_W - DATA_W;

  logic              gate_en_q, gate_en_d;
  logic [GATE_W-1:0] admin_q,   admin_d;
  logic [NS_W-1:0]   ns_q,      ns_d;
  logic [SEC_W-1:0]  sec_q,     sec_d;
  logic              arm_q,     arm_d;
  logic              sw_q,      sw_d;
  logic [CYC_W-1:0]  cyc_q,     cyc_d;
  logic              run_q,     run_d;
  logic [CYC_W-1:0]  acc_q,     acc_d;
  logic              spul_q,    spul_d;
  logic              cpul_q,    cpul_d;

  logic              cmd_wr, match, fire;
  logic [CYC_W:0]    acc_sum;

  always_comb begin
    gate_en_d = gate_en_q;
    admin_d   = admin_q;
    ns_d      = ns_q;
    sec_d     = sec_q;
    arm_d     = arm_q;
    sw_d      = sw_q;
    cyc_d     = cyc_q;
    run_d     = run_q;
    acc_d     = acc_q;
    cpul_d    = 1'b0;

    cmd_wr  = wr_en && (wr_addr == REG_CMD);
    match   = (tod_sec == sec_q) && (tod_ns == ns_q);
    fire    = arm_q && match && !cmd_wr;
    spul_d  = fire;
    acc_sum = {1'b0, acc_q} + {1'b0, ns_delta};

    if (run_q) begin
      if ((cyc_q != '0) && (acc_sum >= {1'b0, cyc_q})) begin
        acc_d  = CYC_W'(acc_sum - {1'b0, cyc_q});
        cpul_d = 1'b1;
      end else begin
        acc_d = acc_sum[CYC_W-1:0];
      end
    end

    if (fire) begin
      arm_d = 1'b0;
      if (sw_q) begin
        run_d  = 1'b1;
        acc_d  = '0;
        cpul_d = 1'b1;
      end
    end

    if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          gate_en_d = wr_data[0];
          admin_d   = wr_data[8 +: GATE_W];
          if (!wr_data[0]) begin
            run_d = 1'b0;
            arm_d = 1'b0;
          end
        end
        REG_NS_LO:  ns_d[DATA_W-1:0]          = wr_data;
        REG_NS_HI:  ns_d[NS_W-1:DATA_W]       = wr_data[NS_HI_W-1:0];
        REG_CMD: begin
          arm_d = wr_data[0];
          sw_d  = wr_data[1];
          sec_d = wr_data[2 +: SEC_W];
        end
        REG_CYC_LO: cyc_d[DATA_W-1:0]         = wr_data;
        REG_CYC_HI: cyc_d[CYC_W-1:DATA_W]     = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_en_q <= 1'b0;
      admin_q   <= '1;
      ns_q      <= '0;
      sec_q     <= '0;
      arm_q     <= 1'b0;
      sw_q      <= 1'b0;
      cyc_q     <= '0;
      run_q     <= 1'b0;
      acc_q     <= '0;
      spul_q    <= 1'b0;
      cpul_q    <= 1'b0;
    end else begin
      gate_en_q <= gate_en_d;
      admin_q   <= admin_d;
      ns_q      <= ns_d;
      sec_q     <= sec_d;
      arm_q     <= arm_d;
      sw_q      <= sw_d;
      cyc_q     <= cyc_d;
      run_q     <= run_d;
      acc_q     <= acc_d;
      spul_q    <= spul_d;
      cpul_q    <= cpul_d;
    end
  end

  assign armed_o       = arm_q;
  assign running_o     = run_q;
  assign hold_o        = gate_en_q && !run_q;
  assign start_pulse_o = spul_q;
  assign cycle_pulse_o = cpul_q;
  assign gate_mask_o   = gate_en_q ? admin_q : '1;
endmodule

// File: rtl/sched_start_arm.sv
module sched_start_arm #(
  parameter int NUM_PORTS = 4,
  parameter int NS_W      = 30,
  parameter int SEC_W     = 3,
  parameter int GATE_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [SEC_W-1:0]            tod_sec,
  input  logic [NS_W-1:0]             tod_ns,
  output logic [NUM_PORTS-1:0]        armed_o,
  output logic [NUM_PORTS-1:0]        running_o,
  output logic [NUM_PORTS-1:0]        hold_o,
  output logic [NUM_PORTS-1:0]        start_pulse_o,
  output logic [NUM_PORTS-1:0]        cycle_pulse_o,
  output logic [NUM_PORTS*GATE_W-1:0] gate_mask_o
);
  import sas_pkg::*;

  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int CYC_W  = 2 * DATA_W;

  logic              rst_meta_q, rst_sync_q;
  logic [PSEL_W-1:0] psel_q, psel_d;
  logic [CYC_W-1:0]  ns_delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  always_comb begin
    psel_d = psel_q;
    if (wr_en && (wr_addr == REG_PSEL)) psel_d = wr_data[PSEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) psel_q <= '0;
    else             psel_q <= psel_d;
  end

  sas_ns_delta #(.NS_W(NS_W), .OUT_W(CYC_W)) u_delta (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .tod_ns  (tod_ns),
    .ns_delta(ns_delta)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic port_wr;
    assign port_wr = wr_en && (wr_addr != REG_PSEL) && (psel_q == PSEL_W'(p));

    sas_port #(.NS_W(NS_W), .SEC_W(SEC_W), .GATE_W(GATE_W), .DATA_W(DATA_W)) u_port (
      .clk          (clk),
      .rst_n        (rst_sync_q),
      .wr_en        (port_wr),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .tod_sec      (tod_sec),
      .tod_ns       (tod_ns),
      .ns_delta     (ns_delta),
      .armed_o      (armed_o[p]),
      .running_o    (running_o[p]),
      .hold_o       (hold_o[p]),
      .start_pulse_o(start_pulse_o[p]),
      .cycle_pulse_o(cycle_pulse_o[p]),
      .gate_mask_o  (gate_mask_o[p*GATE_W +: GATE_W])
    );
  end
endmodule

// File: rtl/sas_checker.sv
module sas_checker #(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [NUM_PORTS-1:0] armed,
  input logic [NUM_PORTS-1:0] running,
  input logic [NUM_PORTS-1:0] hold,
  input logic [NUM_PORTS-1:0] start_pulse,
  input logic [NUM_PORTS-1:0] cycle_pulse
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[p] |-> $past(armed[p])); // R5
    AST_START_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[p] |-> !armed[p]); // R5
    AST_DISARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(armed[p]) && !start_pulse[p]) |-> $past(wr_en)); // R6
    AST_RUN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running[p]) |-> (start_pulse[p] && cycle_pulse[p])); // R7
    AST_HOLD_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold[p]) |-> $past(wr_en)); // R3
  end
endmodule

bind sched_start_arm sas_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .armed      (armed_o),
  .running    (running_o),
  .hold       (hold_o),
  .start_pulse(start_pulse_o),
  .cycle_pulse(cycle_pulse_o)
);

// File: tb/tb_sched_start_arm.sv
module tb_sched_start_arm;
  localparam int NP = 4;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic [2:0]  tod_sec;
  logic [29:0] tod_ns;
  logic [NP-1:0] armed_o, running_o, hold_o, start_pulse_o, cycle_pulse_o;
  logic [NP*8-1:0] gate_mask_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int sec_m;
  int ns_m;

  sched_start_arm dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .armed_o(armed_o), .running_o(running_o),
    .hold_o(hold_o), .start_pulse_o(start_pulse_o), .cycle_pulse_o(cycle_pulse_o),
    .gate_mask_o(gate_mask_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // {start sec[2:0], start ns[29:0], tod sec[7:0], tod ns[29:0], expect fire}
  localparam logic [71:0] VEC [7] = '{
    {3'd2, 30'd5000,      8'd2,  30'd5000,      1'b1},
    {3'd2, 30'd5000,      8'd10, 30'd5000,      1'b1},
    {3'd2, 30'd5000,      8'd3,  30'd5000,      1'b0},
    {3'd2, 30'd5000,      8'd2,  30'd5008,      1'b0},
    {3'd7, 30'd999999992, 8'd15, 30'd999999992, 1'b1},
    {3'd0, 30'd74565,     8'd0,  30'd140101,    1'b0},
    {3'd0, 30'd140101,    8'd16, 30'd140101,    1'b1}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic set_tod(input int s, input int n);
    sec_m = s; ns_m = n;
    tod_sec = 3'(s); tod_ns = 30'(n);
  endtask

  task automatic adv();
    ns_m += 8;
    if (ns_m >= 1000000000) begin ns_m -= 1000000000; sec_m++; end
    tod_sec = 3'(sec_m); tod_ns = 30'(ns_m);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n;
    wr_en = 0; wr_addr = 0; wr_data = 0;
    set_tod(0, 1);
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 armed", 32'(armed_o), 0);
    chk("R1 running", 32'(running_o), 0);
    chk("R1 hold", 32'(hold_o), 0);
    chk("R1 mask", gate_mask_o, 32'hFFFF_FFFF);
    chk("R1 pulses", 32'(start_pulse_o | cycle_pulse_o), 0);

    // R3 enable port 0 with admin 0x3C
    wr(3'd1, 16'h3C01);
    chk("R3 hold", 32'(hold_o[0]), 1);
    chk("R3 mask", 32'(gate_mask_o[7:0]), 32'h3C);
    chk("R2 other port mask", 32'(gate_mask_o[15:8]), 32'hFF);

    // R5 / R4 compare table
    foreach (VEC[i]) begin
      logic [2:0]  ss  = VEC[i][71:69];
      logic [29:0] sns = VEC[i][68:39];
      logic [7:0]  ts  = VEC[i][38:31];
      logic [29:0] tns = VEC[i][30:1];
      logic        ex  = VEC[i][0];
      set_tod(0, 1);
      wr(3'd4, 16'h0000);
      wr(3'd2, sns[15:0]);
      wr(3'd3, {2'b00, sns[29:16]});
      wr(3'd4, 16'(1 | (ss << 2)));
      chk("R4 armed readback", 32'(armed_o[0]), 1);
      set_tod(int'(ts), int'(tns));
      tick();
      chk($sformatf("R5 vec%0d fire", i), 32'(start_pulse_o[0]), 32'(ex));
      chk($sformatf("R5 vec%0d armed", i), 32'(armed_o[0]), 32'(!ex));
      chk($sformatf("R7 vec%0d no switch", i), 32'(running_o[0]), 0);
      set_tod(0, 1);
      tick();
    end
    wr(3'd4, 16'h0000);

    // R7 / R8 short cycle, start at ns 1000 sec 0 with switch
    set_tod(0, 960);
    wr(3'd5, 16'd40);
    wr(3'd6, 16'd0);
    wr(3'd2, 16'd1000);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0003);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      adv(); n++;
      if (start_pulse_o[0]) break;
    end
    chk("R7 start latency", 32'(n), 5);
    chk("R7 cycle pulse at start", 32'(cycle_pulse_o[0]), 1);
    chk("R7 running", 32'(running_o[0]), 1);
    chk("R7 hold off", 32'(hold_o[0]), 0);
    n = 0;
    for (int k = 0; k < 25; k++) begin
      adv();
      if (cycle_pulse_o[0]) n++;
    end
    chk("R8 restarts 40ns", 32'(n), 5);

    // R8 zero cycle time
    wr(3'd5, 16'd0);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      adv();
      if (cycle_pulse_o[0]) n++;
    end
    chk("R8 zero cycle", 32'(n), 0);

    // R3 disable
    wr(3'd1, 16'h3C00);
    chk("R3 disable running", 32'(running_o[0]), 0);
    chk("R3 disable hold", 32'(hold_o[0]), 0);
    chk("R3 disable mask", 32'(gate_mask_o[7:0]), 32'hFF);

    // R8 long cycle across rollover: 65544 ns, start 999990000 at sec 5
    wr(3'd1, 16'h3C01);
    wr(3'd5, 16'h0008);
    wr(3'd6, 16'h0001);
    wr(3'd2, 16'hA2F0);
    wr(3'd3, 16'h3B9A);
    set_tod(13, 999989960);
    wr(3'd4, 16'h0017);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      adv(); n++;
      if (start_pulse_o[0]) break;
    end
    chk("R5 start with seconds 13 mod 8", 32'(n), 5);
    n = 0;
    for (int k = 0; k < 9000; k++) begin
      adv(); n++;
      if (cycle_pulse_o[0]) break;
    end
    chk("R8 first restart ticks", 32'(n), 8193);

    // R6 cancel before instant
    wr(3'd1, 16'hFF00);
    wr(3'd1, 16'hFF01);
    set_tod(0, 1);
    wr(3'd2, 16'd2000);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0000);
    chk("R6 cancel armed", 32'(armed_o[0]), 0);
    set_tod(0, 2000);
    tick();
    chk("R6 no fire after cancel", 32'(start_pulse_o[0]), 0);

    // R6 cancel coinciding with match
    set_tod(0, 1);
    wr(3'd4, 16'h0001);
    set_tod(0, 2000);
    wr(3'd4, 16'h0000);
    chk("R6 same-cycle cancel pulse", 32'(start_pulse_o[0]), 0);
    chk("R6 same-cycle cancel armed", 32'(armed_o[0]), 0);
    set_tod(0, 1);

    // R2 port isolation
    wr(3'd0, 16'd1);
    wr(3'd1, 16'h5A01);
    chk("R2 port1 mask", 32'(gate_mask_o[15:8]), 32'h5A);
    chk("R2 port0 mask kept", 32'(gate_mask_o[7:0]), 32'hFF);
    wr(3'd2, 16'd3000);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0001);
    chk("R2 only port1 armed", 32'(armed_o), 32'b0010);
    set_tod(0, 3000);
    tick();
    chk("R2 only port1 fires", 32'(start_pulse_o), 32'b0010);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule